// File: doc/BRIEF.md
# Laser Transmitter Safety Output Controller

This block sits between a laser driver and its supervisory logic. It sequences power-up and gates the transmitter outputs. A comparator flag reports that the supply is above the power-on threshold. While that flag is low the block holds the transmitter off and reports the power alarm. When the flag rises, the block asks the nonvolatile store to recall its settings, which are the serial device address and the supply low limit. The block then counts out a fixed ready delay and only after that clears its ready-bar status. When the supply dips, the recalled settings are discarded and a fresh recall is requested on the next rise.

Digitized supply samples arrive on a valid/ready stream. The block takes a sample on any cycle where both valid and ready are high. Ready is high only while the supply is above the threshold and the settings have been recalled. A source that sees ready low must hold its sample and valid until ready returns. Each accepted sample sets or clears the supply-low alarm. The first accepted sample above the limit arms the fault path. Before that point the fault input is ignored, so a slow supply ramp cannot produce a spurious transmit fault. Once armed, a fault latches and holds the transmitter off until the transmit-disable input is toggled while the fault is gone.

Top module: `laser_safety_ctrl`

## Requirements
- R1: While `supply_ok_i` is 0 or reset is active, the following hold in the same cycle: `drv_en_o` is 0, `fetg_o` equals `fetg_pol_i` and `tx_fault_o` is 1. From the next clock edge, `rdy_n_o` is 1, `vlow_alarm_o` is 1 and `samp_ready_o` is 0.
- R2: `recall_start_o` is a one-cycle pulse. It is high in the cycle after the first clock edge that samples `supply_ok_i` high. Every later rise of the supply after a dip produces a new pulse.
- R3: `dev_addr_o` is 8'hA2 until the clock edge that samples `recall_done_i` high. From then on it holds the value captured from `recall_addr_i`. It returns to 8'hA2 on the first edge that samples the supply low.
- R4: Let edge k be the edge that sees the supply rise. `rdy_n_o` goes to 0 after edge k+RDY_CYC if the recall is done by then, and otherwise after the edge that sees `recall_done_i`. RDY_CYC is CLK_KHZ*RDY_US/1000.
- R5: `samp_ready_o` is 1 only while the supply is above the threshold and the recall has completed. A sample is taken only on a cycle where both valid and ready are high.
- R6: An accepted sample strictly greater than the recalled limit clears `vlow_alarm_o` after that edge. An accepted sample at or below the limit sets it again.
- R7: Until an accepted sample exceeds the limit after power-up, `fault_i` has no effect on `tx_fault_o`, `drv_en_o` or `fetg_o`.
- R8: After the recall, with the supply good and no latched fault, three cases apply. With `tx_dis_i`=0 and no fault, `drv_en_o`=1 and `fetg_o` is the inverse of `fetg_pol_i`. With `tx_dis_i`=1, `drv_en_o`=0 and `fetg_o` equals `fetg_pol_i`. With an armed fault, for either `tx_dis_i` value, `drv_en_o`=0 and `fetg_o` equals `fetg_pol_i`.
- R9: Once armed, `fault_i`=1 raises `tx_fault_o` in the same cycle, and the fault stays latched after `fault_i` falls. Only two things clear it: a rising edge of `tx_dis_i` sampled while `fault_i` is 0, or a supply loss.
- R10: `drv_en_o` is 0 until the recall has completed, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above power-on threshold |
| samp_valid_i | input | 1 | Supply sample valid |
| samp_ready_o | output | 1 | Supply sample accepted when high with valid |
| samp_data_i | input | ADC_W | Supply sample code |
| tx_dis_i | input | 1 | Transmit disable |
| fault_i | input | 1 | Non-masked fault source |
| fetg_pol_i | input | 1 | FET gate level in the off/alarm state |
| recall_start_o | output | 1 | Request to load nonvolatile settings |
| recall_done_i | input | 1 | Recall finished, settings valid |
| recall_addr_i | input | 8 | Recalled device address |
| recall_lim_i | input | ADC_W | Recalled supply low limit |
| drv_en_o | output | 1 | Modulation and bias enable |
| fetg_o | output | 1 | FET gate output level |
| tx_fault_o | output | 1 | Transmit fault flag |
| vlow_alarm_o | output | 1 | Supply-low alarm |
| rdy_n_o | output | 1 | Ready-bar status |
| dev_addr_o | output | 8 | Current serial device address |

## Verification
The bench ramps the supply slowly. It holds the fault input high and feeds samples below and exactly at the limit, and nothing may reach the fault output. A design that armed on an equal sample, or that latched before arming, would raise a glitching fault here. The bench also drops the supply mid-run and brings it back with a late recall. A design that kept the old address, skipped the second recall request, or cleared ready-bar on the delay alone would be caught. Every row of the output table is driven under both polarity values. The latch is also tested against a transmit-disable edge taken while the fault is still present, which must not clear it.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    S_OFF  = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_RUN  = 2'd3
  } pwr_state_t;

  localparam logic [7:0] DEF_ADDR = 8'hA2;
endpackage

// File: rtl/lsc_power_seq.sv
module lsc_power_seq
  import lsc_pkg::*;
#(
  parameter int ADC_W   = 10,
  parameter int CLK_KHZ = 100000,
  parameter int RDY_US  = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_i,
  input  logic             recall_done_i,
  input  logic [7:0]       recall_addr_i,
  input  logic [ADC_W-1:0] recall_lim_i,
  output logic             recall_start_o,
  output logic             run_o,
  output logic             poa_o,
  output logic             rdy_n_o,
  output logic [7:0]       dev_addr_o,
  output logic [ADC_W-1:0] low_lim_o
);
  localparam int RDY_RAW = (CLK_KHZ * RDY_US) / 1000;
  localparam int RDY_CYC = (RDY_RAW < 1) ? 1 : RDY_RAW;
  localparam int CNT_W   = $clog2(RDY_CYC + 1);

  pwr_state_t       st_q, st_d;
  logic [CNT_W-1:0] dly_q;
  logic [7:0]       addr_q;
  logic [ADC_W-1:0] lim_q;
  logic             dly_full;

  // power alarm: comparator low now, or still sitting in the off state
  assign poa_o = !supply_ok_i || (st_q == S_OFF);

  always_comb begin
    st_d = st_q;
    if (!supply_ok_i) begin
      st_d = S_OFF;
    end else begin
      unique case (st_q)
        S_OFF:   st_d = S_REQ;
        S_REQ:   st_d = S_WAIT;
        S_WAIT:  if (recall_done_i) st_d = S_RUN;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_OFF;
    end else begin
      st_q <= st_d;
    end
  end

  // ready delay counter, restarted by every power alarm
  assign dly_full = (dly_q == CNT_W'(RDY_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
    end else if (poa_o) begin
      dly_q <= '0;
    end else if (!dly_full) begin
      dly_q <= dly_q + 1'b1;
    end
  end

  // recalled settings; defaults come back whenever the supply is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= DEF_ADDR;
      lim_q  <= '1;
    end else if (!supply_ok_i) begin
      addr_q <= DEF_ADDR;
      lim_q  <= '1;
    end else if (st_q == S_WAIT && recall_done_i) begin
      addr_q <= recall_addr_i;
      lim_q  <= recall_lim_i;
    end
  end

  assign run_o          = (st_q == S_RUN);
  assign recall_start_o = (st_q == S_REQ);
  assign rdy_n_o        = !(run_o && dly_full);
  assign dev_addr_o     = addr_q;
  assign low_lim_o      = lim_q;

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start_o |=> !recall_start_o);

  p_addr_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> (dev_addr_o == DEF_ADDR));

  p_ready_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n_o |-> run_o);
endmodule

// File: rtl/lsc_supply_mon.sv
module lsc_supply_mon #(
  parameter int ADC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poa_i,
  input  logic             run_i,
  input  logic             samp_valid_i,
  input  logic [ADC_W-1:0] samp_data_i,
  input  logic [ADC_W-1:0] low_lim_i,
  output logic             samp_ready_o,
  output logic             vlow_o,
  output logic             armed_o
);
  logic vlow_q;
  logic arm_q;
  logic acc;
  logic above;

  assign samp_ready_o = run_i && !poa_i;
  assign acc          = samp_valid_i && samp_ready_o;
  assign above        = (samp_data_i > low_lim_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vlow_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (poa_i) begin
      vlow_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (acc) begin
      vlow_q <= !above;
      if (above) arm_q <= 1'b1;
    end
  end

  assign vlow_o  = vlow_q || poa_i;
  assign armed_o = arm_q;

  p_ready_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    samp_ready_o |-> (run_i && !poa_i));

  p_vlow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vlow_q) |-> $past(acc));

  p_arm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !poa_i) |=> arm_q);
endmodule

// File: rtl/lsc_out_gate.sv
module lsc_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic poa_i,
  input  logic run_i,
  input  logic armed_i,
  input  logic tx_dis_i,
  input  logic fault_i,
  input  logic pol_i,
  output logic drv_en_o,
  output logic fetg_o,
  output logic tx_fault_o
);
  logic tx_dis_q;
  logic flt_lat_q;
  logic fault_now;
  logic clr_edge;
  logic flt;

  assign fault_now = armed_i && fault_i;
  assign clr_edge  = tx_dis_i && !tx_dis_q && !fault_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_dis_q  <= 1'b0;
      flt_lat_q <= 1'b0;
    end else begin
      tx_dis_q <= tx_dis_i;
      if (poa_i) begin
        flt_lat_q <= 1'b0;
      end else if (fault_now) begin
        flt_lat_q <= 1'b1;
      end else if (clr_edge) begin
        flt_lat_q <= 1'b0;
      end
    end
  end

  assign flt        = fault_now || flt_lat_q;
  assign drv_en_o   = run_i && !poa_i && !tx_dis_i && !flt;
  assign fetg_o     = drv_en_o ? !pol_i : pol_i;
  assign tx_fault_o = poa_i || flt;

  p_safe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    poa_i |-> (!drv_en_o && tx_fault_o && (fetg_o == pol_i)));

  p_no_latch_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |=> !flt_lat_q);

  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dis_i || fault_now) |-> (!drv_en_o && (fetg_o == pol_i)));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_lat_q && !poa_i && !tx_dis_i) |=> flt_lat_q);

  p_run_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !drv_en_o);
endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl #(
  parameter int ADC_W   = 10,
  parameter int CLK_KHZ = 100000,
  parameter int RDY_US  = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_i,
  input  logic             samp_valid_i,
  output logic             samp_ready_o,
  input  logic [ADC_W-1:0] samp_data_i,
  input  logic             tx_dis_i,
  input  logic             fault_i,
  input  logic             fetg_pol_i,
  output logic             recall_start_o,
  input  logic             recall_done_i,
  input  logic [7:0]       recall_addr_i,
  input  logic [ADC_W-1:0] recall_lim_i,
  output logic             drv_en_o,
  output logic             fetg_o,
  output logic             tx_fault_o,
  output logic             vlow_alarm_o,
  output logic             rdy_n_o,
  output logic [7:0]       dev_addr_o
);
  logic             run;
  logic             poa;
  logic             armed;
  logic [ADC_W-1:0] low_lim;

  lsc_power_seq #(
    .ADC_W  (ADC_W),
    .CLK_KHZ(CLK_KHZ),
    .RDY_US (RDY_US)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok_i   (supply_ok_i),
    .recall_done_i (recall_done_i),
    .recall_addr_i (recall_addr_i),
    .recall_lim_i  (recall_lim_i),
    .recall_start_o(recall_start_o),
    .run_o         (run),
    .poa_o         (poa),
    .rdy_n_o       (rdy_n_o),
    .dev_addr_o    (dev_addr_o),
    .low_lim_o     (low_lim)
  );

  lsc_supply_mon #(
    .ADC_W(ADC_W)
  ) u_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .poa_i       (poa),
    .run_i       (run),
    .samp_valid_i(samp_valid_i),
    .samp_data_i (samp_data_i),
    .low_lim_i   (low_lim),
    .samp_ready_o(samp_ready_o),
    .vlow_o      (vlow_alarm_o),
    .armed_o     (armed)
  );

  lsc_out_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .poa_i     (poa),
    .run_i     (run),
    .armed_i   (armed),
    .tx_dis_i  (tx_dis_i),
    .fault_i   (fault_i),
    .pol_i     (fetg_pol_i),
    .drv_en_o  (drv_en_o),
    .fetg_o    (fetg_o),
    .tx_fault_o(tx_fault_o)
  );
endmodule

// File: tb/laser_safety_ctrl_tb.sv
module laser_safety_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADC_W      = 10;
  localparam int CLK_KHZ    = 40;
  localparam int RDY_US     = 500;
  localparam int RDY_CYC    = CLK_KHZ * RDY_US / 1000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             supply_ok = 1'b0;
  logic             s_valid = 1'b0;
  logic             s_ready;
  logic [ADC_W-1:0] s_data = '0;
  logic             tx_dis = 1'b0;
  logic             fault = 1'b0;
  logic             pol = 1'b0;
  logic             r_start;
  logic             r_done = 1'b0;
  logic [7:0]       r_addr = 8'h00;
  logic [ADC_W-1:0] r_lim = '0;
  logic             drv_en, fetg, tx_fault, vlow, rdy_n;
  logic [7:0]       dev_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  laser_safety_ctrl #(
    .ADC_W(ADC_W), .CLK_KHZ(CLK_KHZ), .RDY_US(RDY_US)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok),
    .samp_valid_i(s_valid), .samp_ready_o(s_ready), .samp_data_i(s_data),
    .tx_dis_i(tx_dis), .fault_i(fault), .fetg_pol_i(pol),
    .recall_start_o(r_start), .recall_done_i(r_done),
    .recall_addr_i(r_addr), .recall_lim_i(r_lim),
    .drv_en_o(drv_en), .fetg_o(fetg), .tx_fault_o(tx_fault),
    .vlow_alarm_o(vlow), .rdy_n_o(rdy_n), .dev_addr_o(dev_addr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic gate_chk(input string req, input int en_exp, input int flt_exp);
    chk(req, "drv_en", drv_en, en_exp);
    chk(req, "fetg", fetg, en_exp ? int'(!pol) : int'(pol));
    chk(req, "tx_fault", tx_fault, flt_exp);
  endtask

  task automatic send_sample(input int v);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = ADC_W'(v);
    #1 chk("R5", "samp_ready while loaded", s_ready, 1);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    gate_chk("R1", 0, 1);
    chk("R1", "rdy_n in reset", rdy_n, 1);
    chk("R1", "vlow in reset", vlow, 1);
    chk("R3", "default addr", dev_addr, 8'hA2);
    chk("R5", "samp_ready low", s_ready, 0);
  endtask

  task automatic power_up(input logic [7:0] addr, input int lim, input int done_at);
    int last;
    last = (done_at + 3 > RDY_CYC + 3) ? done_at + 3 : RDY_CYC + 3;
    @(negedge clk);
    supply_ok = 1'b1;
    r_addr = addr;
    r_lim  = ADC_W'(lim);
    for (int j = 1; j <= last; j++) begin
      @(negedge clk);
      r_done = (j == done_at);
      chk("R2", "recall_start", r_start, (j == 1) ? 1 : 0);
      chk("R3", "dev_addr", dev_addr, (j > done_at) ? addr : 8'hA2);
      chk("R4", "rdy_n", rdy_n, ((j - 1) >= RDY_CYC && j > done_at) ? 0 : 1);
      if (j == 1) chk("R5", "samp_ready before recall", s_ready, 0);
      if (j == done_at) begin
        #1 chk("R10", "drv_en before recall", drv_en, 0);
      end
      if (j == done_at + 1) chk("R10", "drv_en after recall", drv_en, 1);
    end
    r_done = 1'b0;
  endtask

  task automatic t_slow_ramp();
    @(negedge clk);
    fault = 1'b1;
    #1 gate_chk("R7", 1, 0);
    send_sample(100);
    #1 gate_chk("R7", 1, 0);
    chk("R6", "vlow after low sample", vlow, 1);
    send_sample(300);
    #1 gate_chk("R7", 1, 0);
    chk("R6", "vlow after equal sample", vlow, 1);
    @(negedge clk);
    fault = 1'b0;
    send_sample(301);
    chk("R6", "vlow after sample above", vlow, 0);
    send_sample(200);
    chk("R6", "vlow after later low sample", vlow, 1);
    gate_chk("R7", 1, 0);
  endtask

  task automatic t_fault_latch();
    @(negedge clk);
    fault = 1'b1;
    #1 gate_chk("R9", 0, 1);
    @(negedge clk);
    fault = 1'b0;
    #1 gate_chk("R9", 0, 1);
    @(negedge clk);
    fault = 1'b1;
    tx_dis = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    @(negedge clk);
    tx_dis = 1'b0;
    #1 gate_chk("R9", 0, 1);
    @(negedge clk);
    tx_dis = 1'b1;
    @(negedge clk);
    tx_dis = 1'b0;
    #1 gate_chk("R9", 1, 0);
  endtask

  task automatic t_table();
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      pol = p[0];
      tx_dis = 1'b0; fault = 1'b0;
      #1 gate_chk("R8", 1, 0);
      @(negedge clk);
      tx_dis = 1'b1;
      #1 gate_chk("R8", 0, 0);
      @(negedge clk);
      fault = 1'b1;
      #1 gate_chk("R8", 0, 1);
      @(negedge clk);
      tx_dis = 1'b0;
      #1 gate_chk("R8", 0, 1);
      @(negedge clk);
      fault = 1'b0;
      tx_dis = 1'b1;
      @(negedge clk);
      tx_dis = 1'b0;
      #1 gate_chk("R8", 1, 0);
    end
  endtask

  task automatic t_dip();
    @(negedge clk);
    supply_ok = 1'b0;
    #1 gate_chk("R1", 0, 1);
    @(negedge clk);
    chk("R1", "rdy_n after dip", rdy_n, 1);
    chk("R1", "vlow after dip", vlow, 1);
    chk("R1", "samp_ready after dip", s_ready, 0);
    chk("R3", "addr back to default", dev_addr, 8'hA2);
    power_up(8'h3A, 100, RDY_CYC + 5);
    send_sample(100);
    chk("R6", "vlow equal after recall", vlow, 1);
    send_sample(101);
    chk("R6", "vlow clear with new limit", vlow, 0);
    @(negedge clk);
    fault = 1'b1;
    #1 gate_chk("R9", 0, 1);
    @(negedge clk);
    fault = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    power_up(8'h5C, 300, 6);
    t_slow_ramp();
    t_fault_latch();
    t_table();
    t_dip();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule